// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from sources on the chip and stores each one in a circular buffer in host memory. Each event becomes a fixed 16-byte record. The block owns the producer pointer and software owns the consumer pointer. A level interrupt tells the host that unread records are waiting. After the host consumes records, it writes back its read pointer.

Events arrive on a valid/ready port and wait in a small FIFO. The writer turns each event into four dword memory writes. When the mirror feature is on, a fifth write copies the new producer pointer to a separate memory address. When the ring is full, the writer does not stall. It overwrites the oldest record and raises a sticky overflow flag. Software clears that flag through a control bit and restarts its reads one record past the producer pointer.

Software sets up the block through a flat register port. The port holds the control word, the ring base, both pointers and the mirror address.

Top module: `ivring_writer`

## Requirements
- R1: Dword k (k = 0..3) of a record goes to byte address {BASE[31:0], 8'h00} + (wptr & mask) + 4k, and the dwords are written in the order 0, 1, 2, 3. Dword 0 is {24'h0, src_id}. Dword 1 is {4'h0, src_data}. Dword 2 is {pasid, vm_id, ring_id}, with ring_id in bits [7:0], vm_id in bits [15:8] and pasid in bits [31:16]. Dword 3 is zero.
- R2: After each record, the producer pointer advances by 16 bytes and wraps under mask = (4 << CTRL[8:4]) - 1. CTRL[8:4] is log2 of the ring size in dwords.
- R3: Records are written only while CTRL[0] (interrupt enable) and CTRL[1] (ring enable) are both 1. Until then, events wait in a 4-entry FIFO, and ev_ready is low while the FIFO holds 4 events.
- R4: irq is high exactly when CTRL[0] and CTRL[1] are both 1 and the masked producer and consumer pointers differ.
- R5: While CTRL[3] is 1, a record committed while (wptr + 16) & mask equals the consumer pointer sets the sticky overflow flag, which reads as bit 0 of the WPTR register. Writing continues over the old entries.
- R6: A CTRL write with bit 9 set clears the overflow flag, and bit 9 always reads back as 0. No overflow is flagged while CTRL[3] is 0.
- R7: While CTRL[2] is 1, each record is followed by a write to {WBHI[7:0], WBLO[31:0]} that carries the WPTR register value, including the overflow bit. While CTRL[2] is 0, no such write is made.
- R8: The registers are at these addresses: 0 CTRL, 1 BASE, 2 RPTR, 3 WPTR, 4 WBLO, 5 WBHI. Written values read back. A WPTR write loads bits [31:4] only while CTRL[1] is 0 and is ignored otherwise.
- R9: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold their values into the next cycle.
- R10: After reset, all registers read 0, irq is 0, mem_valid is 0 and ev_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | FIFO has room |
| ev_src_id | input | 8 | Source identifier |
| ev_src_data | input | 28 | Source payload |
| ev_ring_id | input | 8 | Ring identifier |
| ev_vm_id | input | 8 | Virtual machine identifier |
| ev_pasid | input | 16 | Process address space identifier |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on csr_addr) |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 40 | Memory byte address |
| mem_data | output | 32 | Memory write dword |
| irq | output | 1 | Level interrupt: records pending |

## Verification
The hardest state to reach from the ports is the overflow itself. The ring must fill exactly while the host pointer stays still, and the last commit must land with wptr + 16 equal to rptr. The stimulus gets there by queuing four events while the interrupt enable is off. It then enables the block with the consumer pointer parked at the current producer position, so the four records fill a four-record ring and the fourth one trips the flag. The bench also slows the memory port with a repeating not-ready pattern, so that every dword and writeback sees held requests.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int PTR_W  = 32;
  localparam int SZ_W   = 5;
  localparam int ADDR_W = 40;
  localparam int CSR_AW = 3;

  localparam logic [CSR_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [CSR_AW-1:0] RA_BASE = 3'd1;
  localparam logic [CSR_AW-1:0] RA_RPTR = 3'd2;
  localparam logic [CSR_AW-1:0] RA_WPTR = 3'd3;
  localparam logic [CSR_AW-1:0] RA_WBLO = 3'd4;
  localparam logic [CSR_AW-1:0] RA_WBHI = 3'd5;

  typedef struct packed {
    logic [7:0]  src;
    logic [27:0] data;
    logic [7:0]  ring;
    logic [7:0]  vm;
    logic [15:0] pasid;
  } ivr_event_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_D0, PH_D1, PH_D2, PH_D3, PH_WB
  } ivr_phase_e;

  function automatic logic [PTR_W-1:0] ptr_mask(input logic [SZ_W-1:0] sz);
    logic [PTR_W+1:0] m;
    m = ((PTR_W+2)'(4) << sz) - (PTR_W+2)'(1);
    return m[PTR_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p,
                                                 input logic [SZ_W-1:0] sz);
    return (p + PTR_W'(16)) & ptr_mask(sz);
  endfunction

  function automatic logic [31:0] vec_word(input ivr_event_t ev, input logic [1:0] idx);
    case (idx)
      2'd0:    return {24'h0, ev.src};
      2'd1:    return {4'h0, ev.data};
      2'd2:    return {ev.pasid, ev.vm, ev.ring};
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/ivr_evt_fifo.sv
module ivr_evt_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 68
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         rd_pop,
  output logic         rd_avail,
  output logic [W-1:0] rd_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [IW-1:0] wr_ix, rd_ix;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign wr_ready = (cnt != CW'(DEPTH));
  assign rd_avail = (cnt != '0);
  assign rd_data  = store[rd_ix];
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_pop && rd_avail;

  always_ff @(posedge clk) begin
    if (push) store[wr_ix] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ix <= '0;
      rd_ix <= '0;
      cnt   <= '0;
    end else begin
      if (push) wr_ix <= (wr_ix == IW'(DEPTH-1)) ? '0 : wr_ix + 1'b1;
      if (pop)  rd_ix <= (rd_ix == IW'(DEPTH-1)) ? '0 : rd_ix + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ivr_csr.sv
module ivr_csr
  import ivr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CSR_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       wptr_view,
  output logic              intr_en,
  output logic              ring_en,
  output logic              wb_en,
  output logic              ovf_det_en,
  output logic [SZ_W-1:0]   ring_size,
  output logic [31:0]       base_hi,
  output logic [PTR_W-1:0]  rptr,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              ovf_clr,
  output logic              sw_wptr_we,
  output logic [PTR_W-1:0]  sw_wptr_val
);
  logic [31:0] wblo_q;
  logic [7:0]  wbhi_q;
  logic [31:0] ctrl_view;

  assign ctrl_view   = {23'h0, ring_size, ovf_det_en, wb_en, ring_en, intr_en};
  assign wb_addr     = {wbhi_q, wblo_q};
  assign ovf_clr     = we && (addr == RA_CTRL) && wdata[9];
  assign sw_wptr_we  = we && (addr == RA_WPTR) && !ring_en;
  assign sw_wptr_val = {wdata[PTR_W-1:4], 4'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_en    <= 1'b0;
      ring_en    <= 1'b0;
      wb_en      <= 1'b0;
      ovf_det_en <= 1'b0;
      ring_size  <= '0;
      base_hi    <= '0;
      rptr       <= '0;
      wblo_q     <= '0;
      wbhi_q     <= '0;
    end else if (we) begin
      case (addr)
        RA_CTRL: begin
          intr_en    <= wdata[0];
          ring_en    <= wdata[1];
          wb_en      <= wdata[2];
          ovf_det_en <= wdata[3];
          ring_size  <= wdata[8:4];
        end
        RA_BASE: base_hi <= wdata;
        RA_RPTR: rptr    <= wdata;
        RA_WBLO: wblo_q  <= wdata;
        RA_WBHI: wbhi_q  <= wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL: rdata = ctrl_view;
      RA_BASE: rdata = base_hi;
      RA_RPTR: rdata = rptr;
      RA_WPTR: rdata = wptr_view;
      RA_WBLO: rdata = wblo_q;
      RA_WBHI: rdata = {24'h0, wbhi_q};
      default: rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/ivr_emit.sv
module ivr_emit
  import ivr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_en,
  input  logic              wb_en,
  input  logic              ovf_det_en,
  input  logic [SZ_W-1:0]   ring_size,
  input  logic [31:0]       base_hi,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic              evt_avail,
  input  ivr_event_t        evt_head,
  output logic              evt_pop,
  input  logic              sw_wptr_we,
  input  logic [PTR_W-1:0]  sw_wptr_val,
  input  logic              ovf_clr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic [PTR_W-1:0]  wptr,
  output logic              ovf,
  output logic              vec_commit,
  output logic              ovf_set
);
  ivr_phase_e       phase_q;
  ivr_event_t       cur_q;
  logic             beat_done, ring_full;
  logic [1:0]       idx;
  logic [PTR_W-1:0] mask, wptr_next;
  logic [ADDR_W-1:0] vec_addr;

  assign mask       = ptr_mask(ring_size);
  assign wptr_next  = ring_next(wptr, ring_size);
  assign ring_full  = (wptr_next == (rptr & mask));
  assign mem_valid  = (phase_q != PH_IDLE);
  assign beat_done  = mem_valid && mem_ready;
  assign vec_commit = (phase_q == PH_D3) && beat_done;
  assign ovf_set    = vec_commit && ovf_det_en && ring_full;
  assign evt_pop    = (phase_q == PH_IDLE) && go_en && evt_avail;

  always_comb begin
    case (phase_q)
      PH_D1:   idx = 2'd1;
      PH_D2:   idx = 2'd2;
      PH_D3:   idx = 2'd3;
      default: idx = 2'd0;
    endcase
  end

  assign vec_addr = {base_hi, 8'h00} + {8'h00, wptr & mask} + {36'h0, idx, 2'b00};
  assign mem_addr = (phase_q == PH_WB) ? wb_addr : vec_addr;
  assign mem_data = (phase_q == PH_WB) ? {wptr[PTR_W-1:1], ovf} : vec_word(cur_q, idx);

  always_ff @(posedge clk) begin
    if (evt_pop) cur_q <= evt_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wptr    <= '0;
      ovf     <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (evt_pop)   phase_q <= PH_D0;
        PH_D0:   if (beat_done) phase_q <= PH_D1;
        PH_D1:   if (beat_done) phase_q <= PH_D2;
        PH_D2:   if (beat_done) phase_q <= PH_D3;
        PH_D3:   if (beat_done) phase_q <= wb_en ? PH_WB : PH_IDLE;
        PH_WB:   if (beat_done) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
      if (vec_commit)      wptr <= wptr_next;
      else if (sw_wptr_we) wptr <= sw_wptr_val;
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/ivring_writer.sv
module ivring_writer
  import ivr_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [7:0]  ev_src_id,
  input  logic [27:0] ev_src_data,
  input  logic [7:0]  ev_ring_id,
  input  logic [7:0]  ev_vm_id,
  input  logic [15:0] ev_pasid,
  input  logic        csr_we,
  input  logic [2:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [39:0] mem_addr,
  output logic [31:0] mem_data,
  output logic        irq
);
  localparam int EV_W = $bits(ivr_event_t);

  ivr_event_t        ev_in, evt_head;
  logic              evt_avail, evt_pop;
  logic              intr_en, ring_en, wb_en, ovf_det_en;
  logic [SZ_W-1:0]   ring_size;
  logic [31:0]       base_hi;
  logic [PTR_W-1:0]  rptr, wptr, sw_wptr_val, mask;
  logic [ADDR_W-1:0] wb_addr;
  logic              ovf_clr, sw_wptr_we, ovf, vec_commit, ovf_set;

  assign ev_in = '{src: ev_src_id, data: ev_src_data, ring: ev_ring_id,
                   vm: ev_vm_id, pasid: ev_pasid};

  ivr_evt_fifo #(.DEPTH(FIFO_DEPTH), .W(EV_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(ev_valid), .wr_ready(ev_ready), .wr_data(ev_in),
    .rd_pop(evt_pop), .rd_avail(evt_avail), .rd_data(evt_head)
  );

  ivr_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .we(csr_we), .addr(csr_addr), .wdata(csr_wdata), .rdata(csr_rdata),
    .wptr_view({wptr[PTR_W-1:1], ovf}),
    .intr_en(intr_en), .ring_en(ring_en), .wb_en(wb_en), .ovf_det_en(ovf_det_en),
    .ring_size(ring_size), .base_hi(base_hi), .rptr(rptr), .wb_addr(wb_addr),
    .ovf_clr(ovf_clr), .sw_wptr_we(sw_wptr_we), .sw_wptr_val(sw_wptr_val)
  );

  ivr_emit u_emit (
    .clk(clk), .rst_n(rst_n),
    .go_en(intr_en && ring_en), .wb_en(wb_en), .ovf_det_en(ovf_det_en),
    .ring_size(ring_size), .base_hi(base_hi), .rptr(rptr), .wb_addr(wb_addr),
    .evt_avail(evt_avail), .evt_head(evt_head), .evt_pop(evt_pop),
    .sw_wptr_we(sw_wptr_we), .sw_wptr_val(sw_wptr_val), .ovf_clr(ovf_clr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .wptr(wptr), .ovf(ovf), .vec_commit(vec_commit), .ovf_set(ovf_set)
  );

  assign mask = ptr_mask(ring_size);
  assign irq  = intr_en && ring_en && ((wptr & mask) != (rptr & mask));
endmodule

// File: rtl/ivr_check.sv
module ivr_check (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        intr_en,
  input logic        ring_en,
  input logic        ovf_det_en,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [39:0] mem_addr,
  input logic [31:0] mem_data,
  input logic [31:0] wptr,
  input logic        ovf,
  input logic        vec_commit,
  input logic        sw_wptr_we,
  input logic        ovf_clr,
  input logic        evt_pop
);
  // R4
  a_r4_irq_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (intr_en && ring_en));
  // R9
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R2
  a_r2_wptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wptr[3:0] == 4'h0);
  // R2, R8
  a_r2_wptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_commit && !sw_wptr_we) |=> $stable(wptr));
  // R5
  a_r5_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(vec_commit && ovf_det_en));
  // R6
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R3
  a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop |-> (intr_en && ring_en && !mem_valid));
endmodule

bind ivring_writer ivr_check u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .intr_en(intr_en), .ring_en(ring_en),
  .ovf_det_en(ovf_det_en), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .wptr(wptr), .ovf(ovf),
  .vec_commit(vec_commit), .sw_wptr_we(sw_wptr_we), .ovf_clr(ovf_clr),
  .evt_pop(evt_pop)
);

// File: tb/sim_ivring_writer.sv
`timescale 1ns/1ps
module sim_ivring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [7:0]  ev_src_id = '0;
  logic [27:0] ev_src_data = '0;
  logic [7:0]  ev_ring_id = '0;
  logic [7:0]  ev_vm_id = '0;
  logic [15:0] ev_pasid = '0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [39:0] mem_addr;
  logic [31:0] mem_data;
  logic        irq;

  always #10 clk = ~clk;

  ivring_writer u0 (.*);

  // event = {src[67:60], data[59:32], ring[31:24], vm[23:16], pasid[15:0]}
  localparam logic [67:0] TBL [6] = '{
    {8'h11, 28'h0ABCDEF, 8'h01, 8'h02, 16'h0003},
    {8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF},
    {8'h00, 28'h0000000, 8'h00, 8'h00, 16'h0000},
    {8'h5A, 28'h1234567, 8'hA5, 8'h3C, 16'hBEEF},
    {8'h80, 28'h8000001, 8'h7E, 8'h81, 16'h8001},
    {8'h2C, 28'h0F0F0F0, 8'h10, 8'h20, 16'h4242}
  };
  localparam logic [39:0] BASE_ADDR = 40'h0012345600;
  localparam logic [39:0] WB_ADDR   = 40'h5A00001000;
  localparam int          SZ        = 4;

  int n_chk = 0, n_fail = 0, wr_cnt = 0, r9_viol = 0, rdy_cnt = 0;
  bit done = 0;
  logic [31:0] mem_model [logic [39:0]];
  logic        prev_stall = 0;
  logic [39:0] prev_addr = '0;
  logic [31:0] prev_data = '0;

  always @(posedge clk) begin
    if (prev_stall && (!mem_valid || mem_addr != prev_addr || mem_data != prev_data))
      r9_viol++;
    prev_stall = mem_valid && !mem_ready;
    prev_addr  = mem_addr;
    prev_data  = mem_data;
    if (mem_valid && mem_ready) begin
      mem_model[mem_addr] = mem_data;
      wr_cnt++;
    end
  end

  always @(negedge clk) begin
    rdy_cnt++;
    mem_ready <= (rdy_cnt % 3 != 2);
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic send_ev(input logic [67:0] e);
    @(negedge clk);
    ev_valid = 1'b1;
    {ev_src_id, ev_src_data, ev_ring_id, ev_vm_id, ev_pasid} = e;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_writes(input int target, input string req);
    int t = 0;
    while (wr_cnt < target && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk({req, " write count"}, 64'(wr_cnt), 64'(target));
  endtask

  function automatic logic [31:0] exp_word(input logic [67:0] e, input int k);
    case (k)
      0: return 32'(e[67:60]);
      1: return 32'(e[59:32]);
      2: return 32'(e[15:0]) * 32'h10000 + 32'(e[23:16]) * 32'h100 + 32'(e[31:24]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_vec(input logic [67:0] e, input logic [31:0] wp, input string req);
    for (int k = 0; k < 4; k++) begin
      logic [39:0] a;
      a = BASE_ADDR + 40'(wp) + 40'(4 * k);
      chk(req, mem_model.exists(a) ? 64'(mem_model[a]) : 64'hDEAD, 64'(exp_word(e, k)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, mask, exp_w;
    int base_cnt;
    mask = (32'd1 << (SZ + 2)) - 32'd1;
    exp_w = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10
    @(negedge clk);
    chk("R10 irq", 64'(irq), 0);
    chk("R10 ev_ready", 64'(ev_ready), 1);
    chk("R10 mem_valid", 64'(mem_valid), 0);
    csr_rd(3'd3, rd); chk("R10 wptr", 64'(rd), 0);
    csr_rd(3'd0, rd); chk("R10 ctrl", 64'(rd), 0);

    // R8 configuration and readback
    csr_wr(3'd1, 32'h00123456);
    csr_wr(3'd4, 32'h00001000);
    csr_wr(3'd5, 32'h0000005A);
    csr_wr(3'd0, 32'h0000004F);
    csr_rd(3'd0, rd); chk("R8 ctrl readback", 64'(rd), 64'h4F);
    csr_rd(3'd5, rd); chk("R8 wbhi readback", 64'(rd), 64'h5A);
    csr_rd(3'd1, rd); chk("R8 base readback", 64'(rd), 64'h00123456);

    // Table walk: R1 layout, R2 advance/wrap, R7 writeback, R4 irq
    for (int i = 0; i < 6; i++) begin
      base_cnt = wr_cnt;
      send_ev(TBL[i]);
      wait_writes(base_cnt + 5, "R1");
      check_vec(TBL[i], exp_w, "R1 dword");
      exp_w = (exp_w + 32'd16) & mask;
      csr_rd(3'd3, rd); chk("R2 wptr", 64'(rd), 64'(exp_w));
      chk("R7 writeback", 64'(mem_model[WB_ADDR]), 64'(exp_w));
      chk("R4 irq pending", 64'(irq), 1);
      csr_wr(3'd2, exp_w);
      chk("R4 irq idle", 64'(irq), 0);
    end

    // R8: WPTR write ignored while ring enabled
    csr_wr(3'd3, 32'h0);
    csr_rd(3'd3, rd); chk("R8 wptr write ignored", 64'(rd), 64'(exp_w));

    // R3: gating and FIFO backpressure
    csr_wr(3'd0, 32'h0000004E);
    base_cnt = wr_cnt;
    for (int i = 0; i < 4; i++) send_ev(TBL[i]);
    @(negedge clk);
    chk("R3 fifo full ready low", 64'(ev_ready), 0);
    repeat (20) @(negedge clk);
    chk("R3 no writes while disabled", 64'(wr_cnt), 64'(base_cnt));
    chk("R4 irq off when disabled", 64'(irq), 0);

    // R5: drain four records into a four-record ring with rptr parked
    csr_wr(3'd0, 32'h0000004F);
    wait_writes(base_cnt + 20, "R5");
    csr_rd(3'd3, rd); chk("R5 overflow flag", 64'(rd), 64'(exp_w | 32'd1));
    chk("R7 writeback carries overflow", 64'(mem_model[WB_ADDR]), 64'(exp_w | 32'd1));
    check_vec(TBL[3], (exp_w + 32'd48) & mask, "R5 overwrite continues");
    chk("R4 irq equal pointers", 64'(irq), 0);
    chk("R3 ready after drain", 64'(ev_ready), 1);

    // R6: clear the overflow flag
    csr_wr(3'd0, 32'h0000024F);
    csr_rd(3'd3, rd); chk("R6 overflow cleared", 64'(rd), 64'(exp_w));
    csr_rd(3'd0, rd); chk("R6 clear bit reads 0", 64'(rd), 64'h4F);

    // R6: no overflow with detection off
    csr_wr(3'd0, 32'h00000047);
    base_cnt = wr_cnt;
    for (int i = 0; i < 4; i++) send_ev(TBL[i + 2]);
    wait_writes(base_cnt + 20, "R6");
    csr_rd(3'd3, rd); chk("R6 no flag when detect off", 64'(rd), 64'(exp_w));

    // R7: writeback disabled
    csr_wr(3'd0, 32'h00000043);
    mem_model.delete(WB_ADDR);
    base_cnt = wr_cnt;
    send_ev(TBL[5]);
    wait_writes(base_cnt + 4, "R7");
    repeat (10) @(negedge clk);
    chk("R7 no writeback count", 64'(wr_cnt), 64'(base_cnt + 4));
    chk("R7 no writeback", 64'(mem_model.exists(WB_ADDR)), 0);
    check_vec(TBL[5], exp_w, "R1 dword wb off");
    exp_w = (exp_w + 32'd16) & mask;
    chk("R4 irq after record", 64'(irq), 1);

    // R8: software clears pointers while disabled
    csr_wr(3'd0, 32'h00000040);
    csr_wr(3'd3, 32'h0);
    csr_wr(3'd2, 32'h0);
    csr_rd(3'd3, rd); chk("R8 wptr cleared", 64'(rd), 0);
    csr_rd(3'd2, rd); chk("R8 rptr cleared", 64'(rd), 0);
    chk("R4 irq disabled", 64'(irq), 0);

    // R9: requests held through stalls
    chk("R9 held requests", 64'(r9_viol), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule